// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a 16-bit parallel NOR flash that follows the standard command set. The host asks for one of four operations: read the identification words, program one word, erase one block, or put the array back into read mode. The block turns each request into the exact series of bus writes the flash expects. After a program or erase it polls the target location until the flash reports completion. It then sends the read-array command so that normal fetches work again.

Every command except the bare read-array request begins with a two-write unlock prefix at fixed offsets from the flash base address. A command byte occupies the low byte of each 16-bit half of the 32-bit bus word, and both halves carry the same value. The completion poll counts read accesses, not clock cycles. If the count reaches a per-operation limit, the block stops polling, sends the read-array command and reports an error.

The request side is a valid/ready pair. A request is taken on a clock edge where `req_valid` is high and `busy` is low, and `req_ready` equals `!busy`. While the block is busy, requests are dropped, not queued. The bus side is also valid/ready. The flash side holds `bus_ready` low to stretch an access. The block keeps the strobe, the address and the write data steady until the edge on which `bus_ready` is high, and it never has two accesses outstanding.

Top module: `nfs_cmd_seq`

## Requirements
- R1: While reset is held and just after it, `busy`, `done`, `bus_we` and `bus_re` are low and `req_ready` is high.
- R2: Identify, program and erase each start with the write of 0x00AA00AA to base+0xAAA followed by the write of 0x00550055 to base+0x554, with the command byte copied into bits 7:0 and 23:16 and zeros elsewhere.
- R3: Identify (opcode 0) writes 0x00900090 to base+0xAAA after the prefix. It then reads base+0x0, base+0x2 and base+0x4 into `id_mfr`, `id_dev` and `id_prot` (bits 15:0 of the read data), writes 0x00F000F0 to the base, and finishes with `error` low.
- R4: Program (opcode 1) writes 0x00A000A0 to base+0xAAA after the prefix, then writes `req_data` zero-extended to `req_addr`. It reads `req_addr` until bits 15:0 equal `req_data`, then writes 0x00F000F0 to the base and finishes with `error` low.
- R5: Erase (opcode 2) writes 0x00800080 to base+0xAAA after the prefix, then a second prefix, then 0x00300030 to `req_addr`. It reads `req_addr` until bits 15:0 are all ones, then writes 0x00F000F0 to the base.
- R6: Read-array (opcode 3) makes exactly one bus write, 0x00F000F0 to the base, with no prefix, and then finishes.
- R7: If a program or erase has made as many poll reads as its limit without completing, no further poll is made. The next access is the 0x00F000F0 write to the base, and the operation finishes with `error` high. A completion on the last allowed poll is still a success.
- R8: A request is taken only at an edge where `busy` is low, and `busy` is high from the next cycle on. A request presented while `busy` is high has no effect. A request held in the cycle `done` is high is taken at the end of that cycle.
- R9: `done` is high for exactly one cycle per operation, with `busy` low. `error` and the identify fields are valid in that cycle and hold until the next completion.
- R10: `bus_we` and `bus_re` are never high together. Once a strobe is raised, it, `bus_addr` and `bus_wdata` stay unchanged until an edge with `bus_ready` high.
- R11: Wait states from `bus_ready` do not count toward the poll limit. The limit applies to completed poll reads whatever their latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (idle) |
| req_op | input | 2 | 0 identify, 1 program, 2 erase, 3 read-array |
| req_addr | input | AW | Absolute byte address of the target word or block |
| req_data | input | DQ_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last operation hit its poll limit |
| id_mfr | output | DQ_W | Manufacturer word from identify |
| id_dev | output | DQ_W | Device word from identify |
| id_prot | output | DQ_W | Protection word from identify |
| bus_addr | output | AW | Flash bus byte address |
| bus_wdata | output | BW | Flash bus write data |
| bus_we | output | 1 | Write strobe (valid) |
| bus_re | output | 1 | Read strobe (valid) |
| bus_rdata | input | BW | Read data, sampled with bus_ready |
| bus_ready | input | 1 | Access completes on this edge |

## Verification
Two events can coincide in one cycle: the completion pulse of one operation and the taking of the next request. The bench keeps `req_valid` high through a whole program, changing the opcode to read-array once the program has been taken. It then expects `busy` low and `done` high in one cycle, and `busy` high in the next, before any further bus write. The scoreboard must then see the program's writes followed directly by the single read-array write. A second overlap is checked separately: a poll read that completes on the last allowed count must count as a success, not a timeout.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    OP_IDENT = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } nfs_op_e;

  typedef enum logic [2:0] {
    SK_CMD,
    SK_DATA,
    SK_IDRD,
    SK_POLL,
    SK_END
  } nfs_kind_e;

  typedef enum logic [2:0] {
    AS_BASE,
    AS_UNLK_A,
    AS_UNLK_B,
    AS_ID_MFR,
    AS_ID_DEV,
    AS_ID_PROT,
    AS_TGT
  } nfs_asel_e;

  typedef struct packed {
    nfs_kind_e   kind;
    nfs_asel_e   asel;
    logic [7:0]  code;
  } nfs_step_t;

  localparam logic [7:0] CODE_KEY1  = 8'hAA;
  localparam logic [7:0] CODE_KEY2  = 8'h55;
  localparam logic [7:0] CODE_IDENT = 8'h90;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERSU  = 8'h80;
  localparam logic [7:0] CODE_ERBLK = 8'h30;
  localparam logic [7:0] CODE_RDARR = 8'hF0;

  function automatic nfs_step_t mk_step(nfs_kind_e k, nfs_asel_e a, logic [7:0] c);
    nfs_step_t s;
    s.kind = k;
    s.asel = a;
    s.code = c;
    return s;
  endfunction

endpackage

// File: rtl/nfs_seq_table.sv
// Step list per operation: each entry is one bus access or the end marker.
module nfs_seq_table
  import nfs_pkg::*;
(
  input  nfs_op_e          op,
  input  logic [IDX_W-1:0] idx,
  output nfs_step_t        step
);

  always_comb begin
    step = mk_step(SK_END, AS_BASE, 8'h00);
    unique case (op)
      OP_IDENT: begin
        case (idx)
          4'd0: step = mk_step(SK_CMD,  AS_UNLK_A,  CODE_KEY1);
          4'd1: step = mk_step(SK_CMD,  AS_UNLK_B,  CODE_KEY2);
          4'd2: step = mk_step(SK_CMD,  AS_UNLK_A,  CODE_IDENT);
          4'd3: step = mk_step(SK_IDRD, AS_ID_MFR,  8'h00);
          4'd4: step = mk_step(SK_IDRD, AS_ID_DEV,  8'h00);
          4'd5: step = mk_step(SK_IDRD, AS_ID_PROT, 8'h00);
          4'd6: step = mk_step(SK_CMD,  AS_BASE,    CODE_RDARR);
          default: step = mk_step(SK_END, AS_BASE, 8'h00);
        endcase
      end
      OP_PROG: begin
        case (idx)
          4'd0: step = mk_step(SK_CMD,  AS_UNLK_A, CODE_KEY1);
          4'd1: step = mk_step(SK_CMD,  AS_UNLK_B, CODE_KEY2);
          4'd2: step = mk_step(SK_CMD,  AS_UNLK_A, CODE_PROG);
          4'd3: step = mk_step(SK_DATA, AS_TGT,    8'h00);
          4'd4: step = mk_step(SK_POLL, AS_TGT,    8'h00);
          4'd5: step = mk_step(SK_CMD,  AS_BASE,   CODE_RDARR);
          default: step = mk_step(SK_END, AS_BASE, 8'h00);
        endcase
      end
      OP_ERASE: begin
        case (idx)
          4'd0: step = mk_step(SK_CMD,  AS_UNLK_A, CODE_KEY1);
          4'd1: step = mk_step(SK_CMD,  AS_UNLK_B, CODE_KEY2);
          4'd2: step = mk_step(SK_CMD,  AS_UNLK_A, CODE_ERSU);
          4'd3: step = mk_step(SK_CMD,  AS_UNLK_A, CODE_KEY1);
          4'd4: step = mk_step(SK_CMD,  AS_UNLK_B, CODE_KEY2);
          4'd5: step = mk_step(SK_CMD,  AS_TGT,    CODE_ERBLK);
          4'd6: step = mk_step(SK_POLL, AS_TGT,    8'h00);
          4'd7: step = mk_step(SK_CMD,  AS_BASE,   CODE_RDARR);
          default: step = mk_step(SK_END, AS_BASE, 8'h00);
        endcase
      end
      default: begin
        case (idx)
          4'd0: step = mk_step(SK_CMD, AS_BASE, CODE_RDARR);
          default: step = mk_step(SK_END, AS_BASE, 8'h00);
        endcase
      end
    endcase
  end

endmodule

// File: rtl/nfs_bus_master.sv
// One outstanding flash bus access; strobe acts as valid, bus_ready as ready.
module nfs_bus_master #(
  parameter int AW = 32,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [BW-1:0] start_wdata,
  output logic [AW-1:0] bus_addr,
  output logic [BW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [BW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          ack,
  output logic [BW-1:0] rd_data
);

  logic          we_q, re_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] wdata_q;
  logic          active;

  assign active = we_q | re_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= start_we;
      re_q    <= ~start_we;
      addr_q  <= start_addr;
      wdata_q <= start_we ? start_wdata : '0;
    end else if (active && bus_ready) begin
      we_q <= 1'b0;
      re_q <= 1'b0;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_we    = we_q;
  assign bus_re    = re_q;
  assign ack       = active & bus_ready;
  assign rd_data   = bus_rdata;

  // R10: the sequencer never launches a second access over a live one
  p_single_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active)
    else $error("p_single_access_r10");

  // R10: stalled access keeps strobe, address and data steady
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_wdata) &&
                                $stable(bus_we) && $stable(bus_re)))
    else $error("p_hold_stall_r10");

  // R10: read and write strobes are exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re))
    else $error("p_strobe_excl_r10");

endmodule

// File: rtl/nfs_poll_watch.sv
// Counts unsuccessful poll reads and flags the last one permitted.
module nfs_poll_watch #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + 1'b1;
  end

  assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

  // R7: the count of failed polls stays below the limit in force
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt_q < limit))
    else $error("p_cnt_bound_r7");

  // R7: counting is never requested once the last poll is reached
  p_no_inc_past_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last)
    else $error("p_no_inc_past_r7");

endmodule

// File: rtl/nfs_cmd_seq.sv
module nfs_cmd_seq
  import nfs_pkg::*;
#(
  parameter int          AW               = 32,
  parameter int          BW               = 32,
  parameter int          DQ_W             = 16,
  parameter int          CW               = 32,
  parameter logic [31:0] FLASH_BASE       = 32'h1FC0_0000,
  parameter logic [31:0] UNLK_A_OFS       = 32'h0000_0AAA,
  parameter logic [31:0] UNLK_B_OFS       = 32'h0000_0554,
  parameter int unsigned CLK_MHZ          = 100,
  // a poll takes at least two cycles: 512 us and 16 s budgets
  parameter int unsigned PROG_POLL_LIMIT  = 256 * CLK_MHZ,
  parameter int unsigned ERASE_POLL_LIMIT = 8_000_000 * CLK_MHZ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DQ_W-1:0] req_data,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic [DQ_W-1:0] id_mfr,
  output logic [DQ_W-1:0] id_dev,
  output logic [DQ_W-1:0] id_prot,
  output logic [AW-1:0]   bus_addr,
  output logic [BW-1:0]   bus_wdata,
  output logic            bus_we,
  output logic            bus_re,
  input  logic [BW-1:0]   bus_rdata,
  input  logic            bus_ready
);

  localparam int LANES = BW / 16;
  localparam logic [AW-1:0] BASE_A   = AW'(FLASH_BASE);
  localparam logic [AW-1:0] UNLK_A_A = AW'(FLASH_BASE + UNLK_A_OFS);
  localparam logic [AW-1:0] UNLK_B_A = AW'(FLASH_BASE + UNLK_B_OFS);
  localparam logic [CW-1:0] PROG_LIM = CW'(PROG_POLL_LIMIT);
  localparam logic [CW-1:0] ERAS_LIM = CW'(ERASE_POLL_LIMIT);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e              st_q;
  nfs_op_e          op_q;
  logic [AW-1:0]    addr_q;
  logic [DQ_W-1:0]  data_q;
  logic [IDX_W-1:0] idx_q;
  logic             abort_q;
  logic             done_q, err_q;
  logic [DQ_W-1:0]  mfr_q, dev_q, prot_q;

  nfs_step_t        tbl_step, cur;
  logic [AW-1:0]    step_addr;
  logic [BW-1:0]    cmd_word, step_wdata;
  logic             start, ack, last, match, accept;
  logic             poll_clr, poll_inc;
  logic [BW-1:0]    rd_data;
  logic [DQ_W-1:0]  rd_lo;
  logic             unused_rd_hi;
  logic [CW-1:0]    limit;

  nfs_seq_table u_table (
    .op   (op_q),
    .idx  (idx_q),
    .step (tbl_step)
  );

  assign cur = abort_q ? mk_step(SK_CMD, AS_BASE, CODE_RDARR) : tbl_step;

  // command byte copied into each 16-bit half
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cmd_word[g*16 +: 16] = {8'h00, cur.code};
  end

  always_comb begin
    unique case (cur.asel)
      AS_UNLK_A:  step_addr = UNLK_A_A;
      AS_UNLK_B:  step_addr = UNLK_B_A;
      AS_ID_MFR:  step_addr = BASE_A;
      AS_ID_DEV:  step_addr = BASE_A + AW'(2);
      AS_ID_PROT: step_addr = BASE_A + AW'(4);
      AS_TGT:     step_addr = addr_q;
      default:    step_addr = BASE_A;
    endcase
  end

  assign step_wdata = (cur.kind == SK_DATA) ? {{(BW-DQ_W){1'b0}}, data_q} : cmd_word;
  assign start      = (st_q == ST_ISSUE) && (cur.kind != SK_END);

  nfs_bus_master #(.AW(AW), .BW(BW)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_we    ((cur.kind == SK_CMD) || (cur.kind == SK_DATA)),
    .start_addr  (step_addr),
    .start_wdata (step_wdata),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_rdata   (bus_rdata),
    .bus_ready   (bus_ready),
    .ack         (ack),
    .rd_data     (rd_data)
  );

  assign rd_lo        = rd_data[DQ_W-1:0];
  assign unused_rd_hi = ^rd_data[BW-1:DQ_W];
  assign match        = (op_q == OP_ERASE) ? (&rd_lo) : (rd_lo == data_q);
  assign limit        = (op_q == OP_ERASE) ? ERAS_LIM : PROG_LIM;
  assign accept       = (st_q == ST_IDLE) && req_valid;
  assign poll_clr     = accept || (ack && cur.kind == SK_POLL && match);
  assign poll_inc     = ack && (cur.kind == SK_POLL) && !match && !last;

  nfs_poll_watch #(.CW(CW)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (poll_clr),
    .inc   (poll_inc),
    .limit (limit),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_RESET;
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      mfr_q   <= '0;
      dev_q   <= '0;
      prot_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= nfs_op_e'(req_op);
            addr_q  <= req_addr;
            data_q  <= req_data;
            idx_q   <= '0;
            abort_q <= 1'b0;
            st_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (cur.kind == SK_END) begin
            done_q <= 1'b1;
            err_q  <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_WAIT;
          end
        end
        default: begin
          if (ack) begin
            st_q <= ST_ISSUE;
            unique case (cur.kind)
              SK_IDRD: begin
                if (cur.asel == AS_ID_MFR)      mfr_q  <= rd_lo;
                else if (cur.asel == AS_ID_DEV) dev_q  <= rd_lo;
                else                            prot_q <= rd_lo;
                idx_q <= idx_q + 1'b1;
              end
              SK_POLL: begin
                if (match)     idx_q   <= idx_q + 1'b1;
                else if (last) abort_q <= 1'b1;
              end
              default: begin
                if (abort_q) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  st_q   <= ST_IDLE;
                end else begin
                  idx_q <= idx_q + 1'b1;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign req_ready = ~busy;
  assign done      = done_q;
  assign error     = err_q;
  assign id_mfr    = mfr_q;
  assign id_dev    = dev_q;
  assign id_prot   = prot_q;

  // R8: a request seen while idle starts an operation
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy)
    else $error("p_accept_r8");

  // R8: the latched operation cannot change while busy
  p_op_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(op_q)))
    else $error("p_op_hold_r8");

  // R9: completion pulse is one cycle wide and arrives while idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("p_done_pulse_r9");

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy)
    else $error("p_done_idle_r9");

  // R7: the error flag only moves together with completion
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(error) |-> done)
    else $error("p_err_with_done_r7");

  // R10: no bus access while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_we || bus_re))
    else $error("p_idle_quiet_r10");

endmodule

// File: tb/nfs_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nfs_cmd_seq_tb_top;

  localparam logic [31:0] BASE    = 32'h1FC0_0000;
  localparam int          P_LIM   = 6;
  localparam int          E_LIM   = 9;
  localparam logic [15:0] V_MFR   = 16'h0001;
  localparam logic [15:0] V_DEV   = 16'h2249;
  localparam logic [15:0] V_PROT  = 16'h0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        busy, done, error;
  logic [15:0] id_mfr, id_dev, id_prot;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_we, bus_re;
  logic        bus_ready = 1'b0;

  always #2.5 clk = ~clk;

  nfs_cmd_seq #(
    .PROG_POLL_LIMIT (P_LIM),
    .ERASE_POLL_LIMIT(E_LIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .done(done), .error(error),
    .id_mfr(id_mfr), .id_dev(id_dev), .id_prot(id_prot),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- scoreboard of expected bus writes ----------------
  logic [63:0] exp_q[$];

  function automatic logic [31:0] cw(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  task automatic push_w(input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic push_prefix();
    push_w(BASE + 32'hAAA, cw(8'hAA));
    push_w(BASE + 32'h554, cw(8'h55));
  endtask

  task automatic push_seq(input logic [1:0] op, input logic [31:0] a, input logic [15:0] d);
    case (op)
      2'd0: begin push_prefix(); push_w(BASE + 32'hAAA, cw(8'h90)); end
      2'd1: begin push_prefix(); push_w(BASE + 32'hAAA, cw(8'hA0)); push_w(a, {16'h0, d}); end
      2'd2: begin push_prefix(); push_w(BASE + 32'hAAA, cw(8'h80));
                  push_prefix(); push_w(a, cw(8'h30)); end
      default: ;
    endcase
    push_w(BASE, cw(8'hF0));
  endtask

  // ---------------- behavioural flash responder ----------------
  logic [15:0] fmem [0:255];
  int  lat = 0;
  bit  lat_cycle = 1'b0;
  int  wcnt = 0;
  int  ucnt = 0;
  int  arm = 0;          // 1 program armed, 2 erase armed
  bit  id_mode = 1'b0;
  int  busy_polls = 0;
  int  busy_left = 0;
  bit  erase_busy = 1'b0;
  bit  stuck = 1'b0;
  logic [31:0] busy_off = 32'hFFFF_FFFF;
  logic [31:0] tgt_off  = 32'hFFFF_FFFF;
  int  polls = 0;

  initial begin
    for (int i = 0; i < 256; i++) fmem[i] = 16'hFFFF;
    bus_rdata = '0;
  end

  always @(negedge clk) begin
    logic [31:0] off;
    logic [63:0] e;
    if (!rst_n) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_we || bus_re) begin
      if (wcnt >= lat) begin
        bus_ready = 1'b1;
        wcnt = 0;
        off = bus_addr - BASE;
        if (bus_we) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected bus write", {bus_addr, bus_wdata}, 64'h0);
          end else begin
            e = exp_q.pop_front();
            chk({bus_addr, bus_wdata} == e, "R2", "bus write addr/data", {bus_addr, bus_wdata}, e);
          end
          if (off == 0 && bus_wdata[7:0] == 8'hF0) begin
            id_mode = 1'b0; ucnt = 0; arm = 0;
          end else if (arm == 1) begin
            fmem[off[8:1]] = bus_wdata[15:0];
            busy_left = busy_polls; erase_busy = 1'b0; busy_off = off; arm = 0;
          end else if (ucnt == 2 && arm == 2 && bus_wdata[7:0] == 8'h30) begin
            for (int i = 0; i < 256; i++) fmem[i] = 16'hFFFF;
            busy_left = busy_polls; erase_busy = 1'b1; busy_off = off; arm = 0; ucnt = 0;
          end else if (ucnt == 0 && off == 32'hAAA && bus_wdata[7:0] == 8'hAA) begin
            ucnt = 1;
          end else if (ucnt == 1 && off == 32'h554 && bus_wdata[7:0] == 8'h55) begin
            ucnt = 2;
          end else if (ucnt == 2 && off == 32'hAAA) begin
            if (bus_wdata[7:0] == 8'h90) id_mode = 1'b1;
            else if (bus_wdata[7:0] == 8'hA0) arm = 1;
            else if (bus_wdata[7:0] == 8'h80) arm = 2;
            ucnt = 0;
          end else begin
            ucnt = 0;
          end
        end else begin
          if (off == tgt_off) polls++;
          if (id_mode) begin
            bus_rdata = {16'h0, (off == 0) ? V_MFR : (off == 2) ? V_DEV :
                                (off == 4) ? V_PROT : 16'h0};
          end else if (off == busy_off && (stuck || busy_left > 0)) begin
            bus_rdata = {16'h0, erase_busy ? 16'h0000 : (fmem[off[8:1]] ^ 16'h0080)};
            if (busy_left > 0) busy_left--;
          end else begin
            bus_rdata = {16'h0, fmem[off[8:1]]};
          end
        end
        if (lat_cycle) lat = (lat + 1) % 3;
      end else begin
        bus_ready = 1'b0;
        wcnt++;
      end
    end else begin
      bus_ready = 1'b0;
      wcnt = 0;
    end
  end

  // ---------------- driver and completion monitor ----------------
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [15:0] d);
    @(negedge clk);
    push_seq(op, a, d);
    tgt_off = (op == 2'd1 || op == 2'd2) ? (a - BASE) : 32'hFFFF_FFFF;
    polls = 0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, tag, "completion seen", {63'h0, done}, 64'h1);
  endtask

  task automatic finish_op(input string tag, input bit exp_err);
    wait_done(tag);
    chk(!busy, "R9", "busy low with done", {63'h0, busy}, 64'h0);
    chk(error == exp_err, tag, "error flag", {63'h0, error}, {63'h0, exp_err});
    chk(exp_q.size() == 0, tag, "all expected writes seen", exp_q.size(), 64'h0);
    @(negedge clk);
    chk(!done, "R9", "done lasts one cycle", {63'h0, done}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done, "R1", "busy/done in reset", {62'h0, busy, done}, 64'h0);
    chk(!bus_we && !bus_re, "R1", "strobes in reset", {62'h0, bus_we, bus_re}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy, "R1", "ready after reset", {62'h0, req_ready, busy}, 64'h2);
    chk(!done, "R1", "done after reset", {63'h0, done}, 64'h0);

    // R3 identify with one wait state
    lat = 1;
    issue(2'd0, BASE, 16'h0);
    finish_op("R3", 1'b0);
    chk(id_mfr == V_MFR, "R3", "manufacturer word", id_mfr, V_MFR);
    chk(id_dev == V_DEV, "R3", "device word", id_dev, V_DEV);
    chk(id_prot == V_PROT, "R3", "protection word", id_prot, V_PROT);

    // R4 program with three busy polls
    lat = 0; busy_polls = 3;
    issue(2'd1, BASE + 32'h9000, 16'h0011);
    finish_op("R4", 1'b0);
    chk(polls == 4, "R4", "poll reads for program", polls, 4);
    chk(id_mfr == V_MFR, "R9", "identify fields hold", id_mfr, V_MFR);

    // R5 erase with five busy polls, cycling wait states
    lat_cycle = 1'b1; busy_polls = 5;
    issue(2'd2, BASE + 32'h9000, 16'h0);
    finish_op("R5", 1'b0);
    chk(polls == 6, "R5", "poll reads for erase", polls, 6);
    lat_cycle = 1'b0; lat = 0;

    // R6 read-array only
    issue(2'd3, BASE + 32'h1234, 16'h0);
    finish_op("R6", 1'b0);

    // R7 program completes on the last permitted poll
    busy_polls = P_LIM - 1;
    issue(2'd1, BASE + 32'h9002, 16'h00A5);
    finish_op("R7", 1'b0);
    chk(polls == P_LIM, "R7", "success on last poll", polls, P_LIM);

    // R7 program never completes
    stuck = 1'b1; busy_polls = 0;
    issue(2'd1, BASE + 32'h9004, 16'h0042);
    finish_op("R7", 1'b1);
    chk(polls == P_LIM, "R7", "program timeout poll count", polls, P_LIM);

    // R7 R11 erase never completes, with three wait states per access
    lat = 3;
    issue(2'd2, BASE + 32'h9000, 16'h0);
    finish_op("R11", 1'b1);
    chk(polls == E_LIM, "R11", "erase timeout counts polls not cycles", polls, E_LIM);
    stuck = 1'b0; lat = 0;

    // R8 request during busy is dropped
    busy_polls = 4;
    issue(2'd1, BASE + 32'h9006, 16'h0077);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    finish_op("R8", 1'b0);
    repeat (4) @(negedge clk);
    chk(!busy, "R8", "ignored request left block idle", {63'h0, busy}, 64'h0);

    // R8 request held through completion is taken in the done cycle
    busy_polls = 2;
    @(negedge clk);
    push_seq(2'd1, BASE + 32'h9008, 16'h0033);
    push_seq(2'd3, BASE, 16'h0);
    tgt_off = 32'h9008; polls = 0;
    req_valid = 1'b1; req_op = 2'd1; req_addr = BASE + 32'h9008; req_data = 16'h0033;
    @(negedge clk);
    req_op = 2'd3;
    wait_done("R8");
    chk(!busy, "R8", "idle in done cycle", {63'h0, busy}, 64'h0);
    @(negedge clk);
    chk(busy && !done, "R8", "held request taken after done", {62'h0, busy, done}, 64'h2);
    req_valid = 1'b0;
    finish_op("R8", 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule